// File: doc/BRIEF.md
# System Exception Control Register File

This block is the memory-mapped control word set for the core-level exceptions of a small processor. Software reaches it over a simple single-cycle register bus at offsets in the 0xD00 range. It can raise or withdraw the pending state of three exceptions: the non-maskable interrupt, a software-deferred service exception and the periodic tick exception. It also holds the base address of the vector table, twelve 8-bit handler priorities, three fault enables, and a key-guarded request for a system reset.

The block does no arbitration. Its pending, enable and priority outputs go to an external prioritiser. That prioritiser returns four things: the number of the highest pending vector, per-exception active and pending status for the readable status word, and an acknowledge that names the vector it has just taken. A one-cycle pulse from the tick timer also sets the tick pending bit. On every pending bit, any set source wins over any clear source in the same cycle.

Exception numbers used throughout: 2 non-maskable, 4 memory-management fault, 5 bus fault, 6 usage fault, 11 supervisor call, 12 debug, 14 deferred service, 15 tick.

Top module: `sysexc_regs`

## Requirements
- R1: After reset, all three pending outputs are 0, the fault enables are 0, every handler priority is 0, the vector base is 0 and the reset request is low.
- R2: A write to 0xD04 with bit 31 set makes the non-maskable pending output 1 from the next cycle. Writes cannot clear this bit.
- R3: In a write to 0xD04, bit 28 set makes the deferred-service pending bit 1. Bit 27 set with bit 28 clear makes it 0. Otherwise the bit keeps its value.
- R4: In a write to 0xD04, bit 26 set makes the tick pending bit 1. Bit 25 set with bit 26 clear makes it 0. A tick pulse input also sets the bit, and it wins over a bus clear in the same cycle.
- R5: An acknowledge of vector 2, 14 or 15 clears the matching pending bit, unless a set for that bit arrives in the same cycle. An acknowledge of any other vector changes none of the three bits.
- R6: A read of 0xD04 returns the prioritiser's top vector in bits 20:12, tick pending at bit 26, deferred-service pending at bit 28 and non-maskable pending at bit 31. All other bits read 0.
- R7: A write to 0xD08 stores bits 31:7 into the vector base. The base output and a read of 0xD08 both show bits 6:0 as 0.
- R8: A write to 0xD0C with bits 31:16 equal to 0x05FA and bit 2 set raises the reset request for exactly the next cycle. A write with any other key, or without bit 2, does nothing. A read of 0xD0C returns 0.
- R9: The words at 0xD18, 0xD1C and 0xD20 hold the priorities of handlers 4–7, 8–11 and 12–15. Byte k of each word is handler base+k. Priority output bits [8(h-4)+7:8(h-4)] carry handler h, and each word reads back as it was written.
- R10: At 0xD24, bits 16, 17 and 18 are the read/write enables for the memory, bus and usage faults. They drive the fault enable outputs as bits 0, 1 and 2. Other written bits have no effect.
- R11: A read of 0xD24 reports status as follows. Active bits: exception 4 at bit 0, 5 at bit 1, 6 at bit 3, 11 at bit 7, 12 at bit 8, 14 at bit 10 and 15 at bit 11. Pending bits: exception 6 at bit 12, 4 at bit 13, 5 at bit 14 and 11 at bit 15. All other status bits read 0.
- R12: Reads of any other offset return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| tick_pulse | input | 1 | Tick timer expiry, sets tick pending |
| ack_valid | input | 1 | Prioritiser takes an exception this cycle |
| ack_vec | input | 9 | Number of the exception being taken |
| top_vec | input | 9 | Highest pending vector from the prioritiser |
| exc_active | input | 16 | Active status per exception number |
| exc_pending | input | 16 | Pending status per exception number (faults, supervisor call) |
| nmi_pend | output | 1 | Non-maskable interrupt pending |
| defer_pend | output | 1 | Deferred-service exception pending |
| tick_pend | output | 1 | Tick exception pending |
| fault_en | output | 3 | Enables: bit 0 memory, bit 1 bus, bit 2 usage fault |
| handler_prio | output | 96 | Priorities of handlers 4..15, 8 bits each |
| vec_base | output | 32 | Vector table base address |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A write is captured at the clock edge on which the bus presents it, and every register output shows the new value from that edge on. The bench therefore drives on a falling edge and samples one full cycle later, at the next falling edge. Read data is combinational and is sampled 1 ns after the read is driven, within the same cycle. The reset request is high only in the cycle that follows the keyed write, so the bench samples it at the first falling edge after the write and again one cycle later to confirm that it is a single pulse. Acknowledges and tick pulses are driven in the same cycle as bus writes, which exercises the rule that a set wins over a clear.

// File: rtl/sysexc_regs.sv
module sysexc_regs #(
  parameter int ADDR_W   = 12,
  parameter int VEC_W    = 9,
  parameter int PRIO_W   = 8,
  parameter int BASE_LSB = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic                  tick_pulse,
  input  logic                  ack_valid,
  input  logic [VEC_W-1:0]      ack_vec,
  input  logic [VEC_W-1:0]      top_vec,
  input  logic [15:0]           exc_active,
  input  logic [15:0]           exc_pending,
  output logic                  nmi_pend,
  output logic                  defer_pend,
  output logic                  tick_pend,
  output logic [2:0]            fault_en,
  output logic [12*PRIO_W-1:0]  handler_prio,
  output logic [31:0]           vec_base,
  output logic                  reset_req
);
  localparam int NHDL   = 12;
  localparam int NGRP   = NHDL / 4;
  localparam int TOP_LSB = 12;
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'('hD04);
  localparam logic [ADDR_W-1:0] A_VTB  = ADDR_W'('hD08);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'('hD0C);
  localparam logic [ADDR_W-1:0] A_PRI0 = ADDR_W'('hD18);
  localparam logic [ADDR_W-1:0] A_PRI1 = ADDR_W'('hD1C);
  localparam logic [ADDR_W-1:0] A_PRI2 = ADDR_W'('hD20);
  localparam logic [ADDR_W-1:0] A_HCS  = ADDR_W'('hD24);
  localparam logic [15:0] RST_KEY = 16'h05FA;
  localparam int RST_BIT = 2;

  wire wr_en  = bus_sel & bus_wr;
  wire wr_ctl = wr_en && bus_addr == A_CTL;
  wire wr_vtb = wr_en && bus_addr == A_VTB;
  wire wr_rst = wr_en && bus_addr == A_RST;
  wire wr_hcs = wr_en && bus_addr == A_HCS;

  wire ack_nmi  = ack_valid && ack_vec == VEC_W'(2);
  wire ack_def  = ack_valid && ack_vec == VEC_W'(14);
  wire ack_tick = ack_valid && ack_vec == VEC_W'(15);

  wire nmi_set  = wr_ctl & bus_wdata[31];
  wire def_set  = wr_ctl & bus_wdata[28];
  wire def_clr  = (wr_ctl & bus_wdata[27] & ~bus_wdata[28]) | ack_def;
  wire tick_set = (wr_ctl & bus_wdata[26]) | tick_pulse;
  wire tick_clr = (wr_ctl & bus_wdata[25] & ~bus_wdata[26]) | ack_tick;

  logic [31:BASE_LSB] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_pend   <= 1'b0;
      defer_pend <= 1'b0;
      tick_pend  <= 1'b0;
      fault_en   <= '0;
      base_q     <= '0;
      reset_req  <= 1'b0;
    end else begin
      nmi_pend   <= nmi_set  | (nmi_pend   & ~ack_nmi);
      defer_pend <= def_set  | (defer_pend & ~def_clr);
      tick_pend  <= tick_set | (tick_pend  & ~tick_clr);
      if (wr_hcs) fault_en <= bus_wdata[18:16];
      if (wr_vtb) base_q <= bus_wdata[31:BASE_LSB];
      reset_req  <= wr_rst && bus_wdata[31:16] == RST_KEY && bus_wdata[RST_BIT];
    end
  end

  assign vec_base = {base_q, {BASE_LSB{1'b0}}};

  logic [31:0] pri_word [NGRP];

  for (genvar h = 0; h < NHDL; h++) begin : g_prio
    logic [PRIO_W-1:0] q;
    wire hit = wr_en && bus_addr == A_PRI0 + ADDR_W'(4 * (h / 4));
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= bus_wdata[8*(h%4) +: PRIO_W];
    end
    assign handler_prio[h*PRIO_W +: PRIO_W] = q;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_word
    always_comb begin
      pri_word[g] = '0;
      for (int k = 0; k < 4; k++)
        pri_word[g][8*k +: PRIO_W] = handler_prio[(4*g+k)*PRIO_W +: PRIO_W];
    end
  end

  logic [31:0] ctl_word;
  always_comb begin
    ctl_word = '0;
    ctl_word[TOP_LSB +: VEC_W] = top_vec;
    ctl_word[31] = nmi_pend;
    ctl_word[28] = defer_pend;
    ctl_word[26] = tick_pend;
  end

  wire [31:0] hcs_word = {13'b0, fault_en,
                          exc_pending[11], exc_pending[5], exc_pending[4], exc_pending[6],
                          exc_active[15], exc_active[14], 1'b0, exc_active[12], exc_active[11],
                          3'b0, exc_active[6], 1'b0, exc_active[5], exc_active[4]};

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_CTL:   bus_rdata = ctl_word;
        A_VTB:   bus_rdata = vec_base;
        A_PRI0:  bus_rdata = pri_word[0];
        A_PRI1:  bus_rdata = pri_word[1];
        A_PRI2:  bus_rdata = pri_word[2];
        A_HCS:   bus_rdata = hcs_word;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sysexc_regs_chk.sv
module sysexc_regs_chk #(
  parameter int ADDR_W   = 12,
  parameter int VEC_W    = 9,
  parameter int BASE_LSB = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              tick_pulse,
  input logic              ack_valid,
  input logic [VEC_W-1:0]  ack_vec,
  input logic              nmi_pend,
  input logic              defer_pend,
  input logic              tick_pend,
  input logic [31:0]       vec_base,
  input logic              reset_req
);
  wire wr_ctl = bus_sel && bus_wr && bus_addr == ADDR_W'('hD04);

  assert_nmi_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && bus_wdata[31] |=> nmi_pend);

  assert_defer_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && bus_wdata[28] |=> defer_pend);

  assert_tick_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> tick_pend);

  assert_ack_clears_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_vec == VEC_W'(15) && !tick_pulse && !(wr_ctl && bus_wdata[26]) |=> !tick_pend);

  assert_base_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == ADDR_W'('hD08)
    |=> vec_base == {$past(bus_wdata[31:BASE_LSB]), {BASE_LSB{1'b0}}});

  assert_reset_keyed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'('hD0C)
                               && bus_wdata[31:16] == 16'h05FA));

  assert_unimpl_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && bus_addr == ADDR_W'('hD10) |-> bus_rdata == 32'h0);
endmodule

bind sysexc_regs sysexc_regs_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .BASE_LSB(BASE_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_pulse(tick_pulse),
  .ack_valid(ack_valid), .ack_vec(ack_vec), .nmi_pend(nmi_pend), .defer_pend(defer_pend),
  .tick_pend(tick_pend), .vec_base(vec_base), .reset_req(reset_req));

// File: tb/sysexc_regs_test.sv
module sysexc_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        sel = 0, wr = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        tick_pulse = 0, ack_valid = 0;
  logic [8:0]  ack_vec = 0, top_vec = 0;
  logic [15:0] exc_active = 0, exc_pending = 0;
  logic        nmi_pend, defer_pend, tick_pend, reset_req;
  logic [2:0]  fault_en;
  logic [95:0] handler_prio;
  logic [31:0] vec_base;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  sysexc_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .tick_pulse(tick_pulse),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .top_vec(top_vec),
    .exc_active(exc_active), .exc_pending(exc_pending), .nmi_pend(nmi_pend),
    .defer_pend(defer_pend), .tick_pend(tick_pend), .fault_en(fault_en),
    .handler_prio(handler_prio), .vec_base(vec_base), .reset_req(reset_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [11:0] a, input logic [31:0] d, input logic tp,
                       input logic av, input logic [8:0] avec, input logic s);
    @(negedge clk);
    sel = s; wr = s; addr = a; wdata = d; tick_pulse = tp; ack_valid = av; ack_vec = avec;
    @(negedge clk);
    sel = 0; wr = 0; tick_pulse = 0; ack_valid = 0;
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    drive(a, d, 1'b0, 1'b0, 9'd0, 1'b1);
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    sel = 1; wr = 0; addr = a;
    #1 v = rdata;
    sel = 0;
  endtask

  function automatic logic [31:0] act_map(input int e);
    case (e)
      4: return 32'h1;  5: return 32'h2;  6: return 32'h8;
      11: return 32'h80; 12: return 32'h100; 14: return 32'h400; 15: return 32'h800;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] pend_map(input int e);
    case (e)
      6: return 32'h1000; 4: return 32'h2000; 5: return 32'h4000; 11: return 32'h8000;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 nmi", {31'b0, nmi_pend}, 0);
    check("R1 defer", {31'b0, defer_pend}, 0);
    check("R1 tick", {31'b0, tick_pend}, 0);
    check("R1 fault_en", {29'b0, fault_en}, 0);
    check("R1 prio", {31'b0, |handler_prio}, 0);
    check("R1 base", vec_base, 0);
    check("R1 reset_req", {31'b0, reset_req}, 0);

    // R2 non-maskable set
    bwrite(12'hD04, 32'h8000_0000);
    check("R2 nmi set", {31'b0, nmi_pend}, 1);
    bwrite(12'hD04, 32'h0A00_0000);
    check("R2 nmi not cleared by bus", {31'b0, nmi_pend}, 1);

    // R3 / R4 exhaustive set/clear pairs
    for (int st = 0; st < 2; st++)
      for (int b = 0; b < 4; b++) begin
        bwrite(12'hD04, st ? 32'h1400_0000 : 32'h0A00_0000);
        bwrite(12'hD04, (b[1] ? 32'h1000_0000 : 0) | (b[0] ? 32'h0800_0000 : 0));
        check($sformatf("R3 st=%0d b=%0d", st, b), {31'b0, defer_pend},
              {31'b0, b[1] | (st[0] & ~b[0])});
        bwrite(12'hD04, st ? 32'h1400_0000 : 32'h0A00_0000);
        bwrite(12'hD04, (b[1] ? 32'h0400_0000 : 0) | (b[0] ? 32'h0200_0000 : 0));
        check($sformatf("R4 st=%0d b=%0d", st, b), {31'b0, tick_pend},
              {31'b0, b[1] | (st[0] & ~b[0])});
      end
    bwrite(12'hD04, 32'h0200_0000);
    drive(12'h000, 0, 1'b1, 1'b0, 9'd0, 1'b0);
    check("R4 tick pulse sets", {31'b0, tick_pend}, 1);
    bwrite(12'hD04, 32'h0200_0000);
    drive(12'hD04, 32'h0200_0000, 1'b1, 1'b0, 9'd0, 1'b1);
    check("R4 pulse beats bus clear", {31'b0, tick_pend}, 1);

    // R5 acknowledge
    bwrite(12'hD04, 32'h9400_0000);
    drive(12'h000, 0, 1'b0, 1'b1, 9'd3, 1'b0);
    check("R5 ack other vec", {29'b0, nmi_pend, defer_pend, tick_pend}, 3'b111);
    drive(12'h000, 0, 1'b0, 1'b1, 9'd2, 1'b0);
    check("R5 ack nmi", {29'b0, nmi_pend, defer_pend, tick_pend}, 3'b011);
    drive(12'h000, 0, 1'b0, 1'b1, 9'd14, 1'b0);
    check("R5 ack defer", {29'b0, nmi_pend, defer_pend, tick_pend}, 3'b001);
    drive(12'h000, 0, 1'b0, 1'b1, 9'd15, 1'b0);
    check("R5 ack tick", {29'b0, nmi_pend, defer_pend, tick_pend}, 3'b000);
    drive(12'hD04, 32'h1000_0000, 1'b0, 1'b1, 9'd14, 1'b1);
    check("R5 bus set beats ack", {31'b0, defer_pend}, 1);
    drive(12'h000, 0, 1'b1, 1'b1, 9'd15, 1'b0);
    check("R5 pulse beats ack", {31'b0, tick_pend}, 1);
    drive(12'hD04, 32'h8000_0000, 1'b0, 1'b1, 9'd2, 1'b1);
    check("R5 nmi set beats ack", {31'b0, nmi_pend}, 1);

    // R6 control word read: nmi=1, defer/tick cleared
    bwrite(12'hD04, 32'h0A00_0000);
    for (int tv = 0; tv < 512; tv++) begin
      top_vec = 9'(tv);
      bread(12'hD04, v);
      check($sformatf("R6 tv=%0d", tv), v, 32'h8000_0000 | (32'(tv) << 12));
    end
    bwrite(12'hD04, 32'h1400_0000);
    top_vec = 9'h0A5;
    bread(12'hD04, v);
    check("R6 all pend", v, 32'h9400_0000 | (32'h0A5 << 12));

    // R7 vector base
    for (int i = 0; i < 32; i++) begin
      bwrite(12'hD08, 32'h1 << i);
      bread(12'hD08, v);
      check($sformatf("R7 bit %0d read", i), v, (32'h1 << i) & 32'hFFFF_FF80);
      check($sformatf("R7 bit %0d out", i), vec_base, (32'h1 << i) & 32'hFFFF_FF80);
    end
    bwrite(12'hD08, 32'hFFFF_FFFF);
    check("R7 all ones", vec_base, 32'hFFFF_FF80);

    // R8 keyed reset request
    bwrite(12'hD0C, 32'h05FB_0004);
    check("R8 bad key", {31'b0, reset_req}, 0);
    bwrite(12'hD0C, 32'h05FA_0000);
    check("R8 no request bit", {31'b0, reset_req}, 0);
    bwrite(12'hD0C, 32'h05FA_0004);
    check("R8 pulse", {31'b0, reset_req}, 1);
    @(negedge clk);
    check("R8 pulse ends", {31'b0, reset_req}, 0);
    bread(12'hD0C, v);
    check("R8 read zero", v, 0);

    // R9 priorities
    for (int g = 0; g < 3; g++) begin
      logic [31:0] w;
      for (int k = 0; k < 4; k++) w[8*k +: 8] = 8'(37 * (4*g + k) + 5);
      bwrite(12'hD18 + 12'(4*g), w);
    end
    for (int h = 0; h < 12; h++)
      check($sformatf("R9 handler %0d", h + 4), {24'b0, handler_prio[8*h +: 8]},
            {24'b0, 8'(37 * h + 5)});
    for (int g = 0; g < 3; g++) begin
      logic [31:0] w;
      for (int k = 0; k < 4; k++) w[8*k +: 8] = 8'(37 * (4*g + k) + 5);
      bread(12'hD18 + 12'(4*g), v);
      check($sformatf("R9 word %0d", g), v, w);
    end

    // R10 fault enables
    bwrite(12'hD24, 32'hFFFF_FFFF);
    check("R10 all enables", {29'b0, fault_en}, 7);
    bwrite(12'hD24, 32'h0005_0000);
    check("R10 mem+usage", {29'b0, fault_en}, 5);
    bread(12'hD24, v);
    check("R10 read", v, 32'h0005_0000);
    bwrite(12'hD24, 32'h0007_0000);

    // R11 status mapping
    for (int e = 0; e < 16; e++) begin
      exc_active = 16'h1 << e;
      bread(12'hD24, v);
      check($sformatf("R11 active %0d", e), v, 32'h0007_0000 | act_map(e));
    end
    exc_active = 0;
    for (int e = 0; e < 16; e++) begin
      exc_pending = 16'h1 << e;
      bread(12'hD24, v);
      check($sformatf("R11 pending %0d", e), v, 32'h0007_0000 | pend_map(e));
    end
    exc_pending = 0;

    // R12 unimplemented offsets
    begin
      logic [11:0] offs [8] = '{12'hD00, 12'hD10, 12'hD14, 12'hD28, 12'hD2C, 12'hD40, 12'h000, 12'hFFC};
      for (int i = 0; i < 8; i++) begin
        bwrite(offs[i], 32'hFFFF_FFFF);
        bread(offs[i], v);
        check($sformatf("R12 read %h", offs[i]), v, 0);
      end
    end
    check("R12 base kept", vec_base, 32'hFFFF_FF80);
    check("R12 enables kept", {29'b0, fault_en}, 7);
    check("R12 pend kept", {29'b0, nmi_pend, defer_pend, tick_pend}, 3'b111);
    check("R12 prio kept", handler_prio[95:64], {8'(37*11+5), 8'(37*10+5), 8'(37*9+5), 8'(37*8+5)});
    check("R12 no reset", {31'b0, reset_req}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule